// File: doc/BRIEF.md
# Strict-Plus-Weighted Output Queue Scheduler

This block decides which of up to eight command queues that feed a single output port gets the next packet slot. Every queue has a 4-bit priority setting. Setting 9 makes a queue a strict-priority queue. Strict queues are always served ahead of the others, and the lowest-numbered one wins. Settings 0 through 8 make a queue a weighted queue. Weighted queues share the port over a repeating cycle of eight rounds. Each setting is turned into an 8-bit round mask whose set bits are spread out evenly, and a weighted queue may only be served in the rounds where its mask bit is set.

A grant is given as `grant_valid` together with `grant_qid`. It stays up until the consumer pulses `pkt_done`. The block also checks the configuration it is given. It raises one flag for an out-of-range priority setting, and another when the strict queues do not form one unbroken run that starts at queue 0. Only the queues below `port_qcnt` belong to the port. The last queue of the port ends every scan.

Top module: `wrr_static_sched`

## Requirements
- R1: Weighted settings map to these round masks: 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7f, 8→0xff. In round r, which counts 0 to 7, a weighted queue can be granted only if mask bit r is 1. After reset the first round is round 0.
- R2: A queue with setting 0 is never granted. When a setting-8 queue and a setting-1 queue are both always ready, the setting-8 queue gets 8 grants for every 1 grant to the setting-1 queue.
- R3: A ready strict queue (setting 9) is granted before any weighted queue. Among ready strict queues the lowest queue number is granted.
- R4: If, among the queues in the port, a setting-9 queue follows a queue that is not setting 9, `err_static_order` is 1. In that case every setting-9 queue is scheduled as a weighted queue with mask 0xff.
- R5: A setting above 9 on a queue in the port sets `err_prio` to 1, and that queue uses mask 0xff.
- R6: Within one round, weighted queues are granted in ascending order. Each scan starts just after the queue granted last. The round advances only when no eligible ready queue remains from that point up to the end of the port.
- R7: `grant_valid` and `grant_qid` stay constant until `pkt_done` is sampled high. `grant_valid` is low in the following cycle.
- R8: When no queue in the port is ready and either strict or carrying a nonzero mask, `grant_valid` stays low. A grant only goes to a queue whose `q_nonempty` bit was 1 in the cycle before the grant.
- R9: A changed priority setting takes effect only at the next round boundary. The rest of the current round still uses the old mask.
- R10: Queues with an index at or above `port_qcnt` are never granted.
- R11: During and right after reset, `grant_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prio_cfg | input | 4*NQ | Priority setting of queue i in bits [4i+3:4i] |
| port_qcnt | input | $clog2(NQ)+1 | Number of queues that belong to the port |
| q_nonempty | input | NQ | Queue i holds at least one command |
| pkt_done | input | 1 | Consumer finished the granted packet |
| grant_valid | output | 1 | A grant is outstanding |
| grant_qid | output | $clog2(NQ) | Queue that holds the grant |
| err_prio | output | 1 | Some queue in the port has a setting above 9 |
| err_static_order | output | 1 | Strict queues are not one run starting at queue 0 |

## Verification
The properties assume that `port_qcnt` only changes while reset is asserted. They also assume that `pkt_done` is pulsed only while a grant is outstanding. The bench changes the queue count and the port layout only under reset. It raises `pkt_done` for exactly one cycle, and only after it has seen `grant_valid`. `q_nonempty` and the priority settings are changed at falling edges. This lets the R9 test rewrite a setting partway through a round without clashing with the registers that capture it.

// File: rtl/wrr_sched_pkg.sv
package wrr_sched_pkg;
  localparam int PRIO_W   = 4;
  localparam int ROUNDS   = 8;
  localparam int RND_W    = $clog2(ROUNDS);
  localparam logic [PRIO_W-1:0] PRIO_STRICT = 4'd9;

  typedef logic [ROUNDS-1:0] rmask_t;

  // Spread set bits evenly across the eight rounds.
  function automatic rmask_t prio_to_mask(input logic [PRIO_W-1:0] p);
    case (p)
      4'd0:    prio_to_mask = 8'h00;
      4'd1:    prio_to_mask = 8'h01;
      4'd2:    prio_to_mask = 8'h11;
      4'd3:    prio_to_mask = 8'h49;
      4'd4:    prio_to_mask = 8'h55;
      4'd5:    prio_to_mask = 8'h57;
      4'd6:    prio_to_mask = 8'h77;
      4'd7:    prio_to_mask = 8'h7f;
      default: prio_to_mask = 8'hff;
    endcase
  endfunction
endpackage

// File: rtl/wrr_cfg_decode.sv
module wrr_cfg_decode
  import wrr_sched_pkg::*;
#(
  parameter int NQ = 8,
  localparam int CW = $clog2(NQ) + 1
) (
  input  logic [NQ*PRIO_W-1:0] prio_cfg,
  input  logic [CW-1:0]        port_qcnt,
  output rmask_t [NQ-1:0]      mask,
  output logic [NQ-1:0]        strict_vec,
  output logic [NQ-1:0]        in_port,
  output logic                 err_prio,
  output logic                 err_order
);
  logic [NQ-1:0] is_strict;
  logic [NQ-1:0] is_tail;
  logic [NQ-1:0] bad_val;
  logic [NQ-1:0] strict_in;

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic [PRIO_W-1:0] p;
    assign p            = prio_cfg[i*PRIO_W +: PRIO_W];
    assign mask[i]      = prio_to_mask(p);
    assign is_strict[i] = (p == PRIO_STRICT);
    assign bad_val[i]   = (p > PRIO_STRICT) && in_port[i];
    assign is_tail[i]   = (CW'(i) + CW'(1)) == port_qcnt;
    assign in_port[i]   = CW'(i) < port_qcnt;
    assign strict_in[i] = is_strict[i] && in_port[i];
  end

  // A strict run may only start at queue 0 and must not resume after a gap.
  always_comb begin
    err_order = 1'b0;
    for (int i = 1; i < NQ; i++) begin
      if (strict_in[i] && !strict_in[i-1] && !is_tail[i-1]) err_order = 1'b1;
    end
  end

  assign err_prio   = |bad_val;
  assign strict_vec = err_order ? '0 : strict_in;
endmodule

// File: rtl/wrr_pick.sv
module wrr_pick #(
  parameter int NQ = 8,
  localparam int IW = $clog2(NQ),
  localparam int CW = $clog2(NQ) + 1
) (
  input  logic [NQ-1:0] req,
  input  logic [CW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (req[i] && (CW'(i) >= start)) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wrr_static_sched.sv
module wrr_static_sched
  import wrr_sched_pkg::*;
#(
  parameter int NQ = 8,
  localparam int IW = $clog2(NQ),
  localparam int CW = $clog2(NQ) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NQ*PRIO_W-1:0] prio_cfg,
  input  logic [CW-1:0]        port_qcnt,
  input  logic [NQ-1:0]        q_nonempty,
  input  logic                 pkt_done,
  output logic                 grant_valid,
  output logic [IW-1:0]        grant_qid,
  output logic                 err_prio,
  output logic                 err_static_order
);
  // Live decode of configuration
  rmask_t [NQ-1:0] mask_live;
  logic [NQ-1:0]   strict_live;
  logic [NQ-1:0]   inport_live;

  wrr_cfg_decode #(.NQ(NQ)) u_dec (
    .prio_cfg  (prio_cfg),
    .port_qcnt (port_qcnt),
    .mask      (mask_live),
    .strict_vec(strict_live),
    .in_port   (inport_live),
    .err_prio  (err_prio),
    .err_order (err_static_order)
  );

  // Configuration captured at round boundaries
  rmask_t [NQ-1:0] mask_q,   mask_n;
  logic [NQ-1:0]   strict_q, strict_n;
  logic [NQ-1:0]   inport_q, inport_n;
  logic [RND_W-1:0] round_q, round_n;
  logic [CW-1:0]    ptr_q,   ptr_n;
  logic             busy_q,  busy_n;
  logic [IW-1:0]    gid_q,   gid_n;

  logic [NQ-1:0] strict_req;
  logic [NQ-1:0] wgt_req;
  logic [NQ-1:0] serviceable;
  logic          s_found, w_found;
  logic [IW-1:0] s_idx, w_idx;
  logic          load_cfg;

  for (genvar i = 0; i < NQ; i++) begin : g_req
    assign strict_req[i]  = strict_q[i] && inport_q[i] && q_nonempty[i];
    assign wgt_req[i]     = !strict_q[i] && inport_q[i] && q_nonempty[i]
                            && mask_q[i][round_q];
    assign serviceable[i] = inport_live[i] && q_nonempty[i]
                            && (strict_live[i] || (|mask_live[i]));
  end

  wrr_pick #(.NQ(NQ)) u_pick_strict (
    .req  (strict_req),
    .start(CW'(0)),
    .found(s_found),
    .idx  (s_idx)
  );

  wrr_pick #(.NQ(NQ)) u_pick_wgt (
    .req  (wgt_req),
    .start(ptr_q),
    .found(w_found),
    .idx  (w_idx)
  );

  // Next-state logic
  always_comb begin
    busy_n   = busy_q;
    gid_n    = gid_q;
    round_n  = round_q;
    ptr_n    = ptr_q;
    load_cfg = 1'b0;
    if (busy_q) begin
      if (pkt_done) busy_n = 1'b0;
    end else if (s_found) begin
      busy_n = 1'b1;
      gid_n  = s_idx;
    end else if (w_found) begin
      busy_n = 1'b1;
      gid_n  = w_idx;
      ptr_n  = CW'(w_idx) + CW'(1);
    end else if (|serviceable) begin
      round_n  = round_q + RND_W'(1);
      ptr_n    = '0;
      load_cfg = 1'b1;
    end
  end

  always_comb begin
    mask_n   = load_cfg ? mask_live   : mask_q;
    strict_n = load_cfg ? strict_live : strict_q;
    inport_n = load_cfg ? inport_live : inport_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      gid_q    <= '0;
      round_q  <= RND_W'(ROUNDS - 1);
      ptr_q    <= CW'(NQ);
      mask_q   <= '0;
      strict_q <= '0;
      inport_q <= '0;
    end else begin
      busy_q  <= busy_n;
      gid_q   <= gid_n;
      round_q <= round_n;
      ptr_q   <= ptr_n;
      if (load_cfg) begin
        mask_q   <= mask_n;
        strict_q <= strict_n;
        inport_q <= inport_n;
      end
    end
  end

  assign grant_valid = busy_q;
  assign grant_qid   = gid_q;
endmodule

// File: rtl/wrr_static_sched_chk.sv
module wrr_static_sched_chk #(
  parameter int NQ = 8,
  localparam int IW = $clog2(NQ),
  localparam int CW = $clog2(NQ) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] port_qcnt,
  input logic [NQ-1:0] q_nonempty,
  input logic          pkt_done,
  input logic          grant_valid,
  input logic [IW-1:0] grant_qid
);
  // R7
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !pkt_done) |=> (grant_valid && $stable(grant_qid)));

  // R7
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && pkt_done) |=> !grant_valid);

  // R8
  grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> (($past(q_nonempty) >> grant_qid) & NQ'(1)) != '0);

  // R10
  grant_in_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> (CW'(grant_qid) < port_qcnt));
endmodule

bind wrr_static_sched wrr_static_sched_chk #(.NQ(NQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_qcnt  (port_qcnt),
  .q_nonempty (q_nonempty),
  .pkt_done   (pkt_done),
  .grant_valid(grant_valid),
  .grant_qid  (grant_qid)
);

// File: tb/wrr_static_sched_test.sv
module wrr_static_sched_test;
  localparam int NQ = 8;
  localparam int IW = $clog2(NQ);
  localparam int CW = $clog2(NQ) + 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NQ*4-1:0] prio_cfg;
  logic [CW-1:0]   port_qcnt;
  logic [NQ-1:0]   q_nonempty;
  logic            pkt_done;
  logic            grant_valid;
  logic [IW-1:0]   grant_qid;
  logic            err_prio;
  logic            err_static_order;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  wrr_static_sched #(.NQ(NQ)) uut (
    .clk(clk), .rst_n(rst_n), .prio_cfg(prio_cfg), .port_qcnt(port_qcnt),
    .q_nonempty(q_nonempty), .pkt_done(pkt_done), .grant_valid(grant_valid),
    .grant_qid(grant_qid), .err_prio(err_prio), .err_static_order(err_static_order)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] exp_mask(input int p);
    case (p)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h11;
      3: return 8'h49; 4: return 8'h55; 5: return 8'h57;
      6: return 8'h77; 7: return 8'h7f; default: return 8'hff;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_prio(input int q, input int p);
    prio_cfg[q*4 +: 4] = 4'(p);
  endtask

  task automatic do_reset(input int qcnt);
    @(negedge clk);
    rst_n      = 1'b0;
    pkt_done   = 1'b0;
    q_nonempty = '0;
    prio_cfg   = '0;
    port_qcnt  = CW'(qcnt);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Wait for a grant, return its queue id, then finish the packet.
  task automatic take(output int id, input bit finish);
    int n = 0;
    id = -1;
    while (!grant_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    if (grant_valid) id = int'(grant_qid);
    if (finish && grant_valid) begin
      pkt_done = 1'b1;
      @(negedge clk);
      pkt_done = 1'b0;
    end
  endtask

  task automatic expect_grant(input int exp, input string req);
    int id;
    take(id, 1'b1);
    check(id == exp, req, id, exp);
  endtask

  // R11: reset state
  task automatic t_reset;
    do_reset(8);
    check(grant_valid == 1'b0, "R11", int'(grant_valid), 0);
    @(negedge clk);
    check(grant_valid == 1'b0 && !err_prio && !err_static_order, "R11",
          int'(grant_valid), 0);
  endtask

  // R1 / R2: full eight-round pattern for every weighted setting
  task automatic t_masks;
    for (int p = 0; p <= 8; p++) begin
      logic [7:0] m = exp_mask(p);
      do_reset(8);
      set_prio(0, 8); set_prio(1, p);
      q_nonempty = 8'h03;
      for (int r = 0; r < 8; r++) begin
        expect_grant(0, "R1");
        if (m[r]) expect_grant(1, (p == 0) ? "R2" : "R1");
      end
    end
  endtask

  // R3: strict queues win, lowest first
  task automatic t_strict;
    do_reset(8);
    set_prio(0, 9); set_prio(1, 9); set_prio(2, 8);
    q_nonempty = 8'h07;
    expect_grant(0, "R3");
    expect_grant(0, "R3");
    q_nonempty = 8'h06;
    expect_grant(1, "R3");
    q_nonempty = 8'h04;
    expect_grant(2, "R3");
  endtask

  // R4: broken strict run
  task automatic t_order;
    do_reset(8);
    set_prio(0, 4); set_prio(1, 9);
    q_nonempty = 8'h03;
    @(negedge clk);
    check(err_static_order == 1'b1, "R4", int'(err_static_order), 1);
    expect_grant(0, "R4");
    expect_grant(1, "R4");
    expect_grant(1, "R4");
    do_reset(8);
    set_prio(0, 9); set_prio(1, 8); set_prio(2, 9);
    @(negedge clk);
    check(err_static_order == 1'b1, "R4", int'(err_static_order), 1);
    set_prio(2, 8);
    @(negedge clk);
    check(err_static_order == 1'b0, "R4", int'(err_static_order), 0);
  endtask

  // R5: out-of-range setting acts as 0xff
  task automatic t_badprio;
    int cnt1 = 0;
    int id;
    do_reset(8);
    set_prio(0, 1); set_prio(1, 12);
    q_nonempty = 8'h03;
    @(negedge clk);
    check(err_prio == 1'b1, "R5", int'(err_prio), 1);
    for (int k = 0; k < 9; k++) begin
      take(id, 1'b1);
      if (id == 1) cnt1++;
    end
    check(cnt1 == 8, "R5", cnt1, 8);
  endtask

  // R6: ascending order, resuming after last grant
  task automatic t_rr;
    do_reset(8);
    set_prio(0, 8); set_prio(1, 8); set_prio(2, 8);
    q_nonempty = 8'h07;
    for (int k = 0; k < 6; k++) expect_grant(k % 3, "R6");
  endtask

  // R7: grant held until done
  task automatic t_hold;
    int id;
    do_reset(8);
    set_prio(5, 8);
    q_nonempty = 8'h20;
    take(id, 1'b0);
    repeat (5) @(negedge clk);
    check(grant_valid && grant_qid == 3'd5, "R7", int'(grant_qid), 5);
    pkt_done = 1'b1;
    @(negedge clk);
    pkt_done   = 1'b0;
    q_nonempty = '0;
    check(grant_valid == 1'b0, "R7", int'(grant_valid), 0);
  endtask

  // R8: idle port, then a queue becomes ready
  task automatic t_idle;
    bit seen = 1'b0;
    do_reset(8);
    set_prio(3, 8); set_prio(4, 0);
    q_nonempty = 8'h10;
    repeat (20) begin
      @(negedge clk);
      if (grant_valid) seen = 1'b1;
    end
    check(!seen, "R8", int'(seen), 0);
    q_nonempty = 8'h18;
    expect_grant(3, "R8");
  endtask

  // R9: rewrite takes effect at round boundary
  task automatic t_rewrite;
    do_reset(8);
    set_prio(0, 8); set_prio(1, 8);
    q_nonempty = 8'h03;
    expect_grant(0, "R9");
    set_prio(1, 0);
    expect_grant(1, "R9");
    for (int k = 0; k < 3; k++) expect_grant(0, "R9");
  endtask

  // R10: queues outside the port
  task automatic t_port;
    bit seen = 1'b0;
    do_reset(2);
    set_prio(1, 8); set_prio(2, 8);
    q_nonempty = 8'h04;
    repeat (20) begin
      @(negedge clk);
      if (grant_valid) seen = 1'b1;
    end
    check(!seen, "R10", int'(seen), 0);
    q_nonempty = 8'h06;
    expect_grant(1, "R10");
    expect_grant(1, "R10");
  endtask

  initial begin
    rst_n = 1'b0; pkt_done = 1'b0; q_nonempty = '0; prio_cfg = '0;
    port_qcnt = CW'(8);
    t_reset();
    t_masks();
    t_strict();
    t_order();
    t_badprio();
    t_rr();
    t_hold();
    t_idle();
    t_rewrite();
    t_port();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule